// File: doc/BRIEF.md
# Bit-Serial CRC-16 Generator and Checker for Synchronous Link Frames

This block computes the 16-bit check sequence of a serial frame one bit per clock, using the generator x^16 + x^12 + x^5 + 1. It is meant to sit next to a synchronous serial framer that sends each byte least significant bit first. The block takes the bits in that same order. A start-of-frame strobe loads the register with all ones. Each qualified data bit then updates the register. The incoming bit is folded into the feedback term, so the message never needs zero padding.

In the transmit direction, the bit that closes the data phase is marked with `data_last`. The block then shifts out the 16 check bits, leading register bit first, and inverts them while `inv_en` is high. It raises `tx_done` together with the sixteenth bit. In the receive direction, the frame and its received check bits are fed in without `data_last`. `crc_ok` then shows whether the register holds the residue that a clean frame leaves behind. That residue is all zeros for plain check bits and 0xF0B8 for inverted ones. The register value is also visible in parallel for test.

The controller is a three-state machine:
- **IDLE**: nothing is absorbed and the register holds.
- **ABSORB**: qualified bits update the register.
- **EMIT**: the check bits are shifted out over 16 clocks.

Transitions:
- IDLE→ABSORB or ABSORB→ABSORB on `sof`.
- ABSORB→EMIT on a valid bit carrying `data_last`.
- EMIT→IDLE after the sixteenth output bit.
- EMIT→ABSORB when `sof` aborts an emission.
- Any state→EMIT when `sof` coincides with a valid last bit.

Top module: `crc16_serial`

## Requirements
- R1: After synchronous reset, and after a `sof` with `bit_vld` low, `crc_q` reads 0xFFFF. After reset, `tx_vld` and `tx_done` are 0.
- R2: In ABSORB, each cycle with `bit_vld` high applies one update to the reflected register, with polynomial mask 0x8408, bit 0 as the leading bit, and `bit_in` XORed into the feedback. `crc_q` equals the bit-reversal of an MSB-first CRC that uses polynomial 0x1021 and preset 0xFFFF over the same bit stream.
- R3: For the single byte 0x41 sent LSB first, the emitted check bits in transmit order are 0101000000111010 when `inv_en`=0 and 1010111111000101 when `inv_en`=1.
- R4: A valid bit with `data_last`=1 moves the block to EMIT. On each of the next 16 clocks `tx_vld`=1 and `tx_bit` = `crc_q[0]` XOR `inv_en`, with the register shifting toward bit 0. `tx_done`=1 only on the sixteenth clock. After that, `tx_vld` returns to 0.
- R5: `crc_ok`=1 exactly when `crc_q`=0x0000 with `inv_en`=0, or when `crc_q`=0xF0B8 with `inv_en`=1. A clean received frame plus its check bits sets `crc_ok`. A flipped bit clears it. One extra trailing zero clears it when `inv_en`=1.
- R6: `sof` has priority in every state. If `bit_vld` is also high, the register is preset and then that bit is absorbed as the first frame bit. A `sof` during EMIT aborts the emission.
- R7: `bit_vld` has no effect in IDLE or EMIT, and `data_last` has no effect outside ABSORB. A cycle in ABSORB with `bit_vld` low leaves `crc_q` unchanged.
- R8: After a complete emission, `crc_q` reads 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sof | input | 1 | Start of frame: presets the register to all ones |
| bit_vld | input | 1 | Qualifies `bit_in` |
| bit_in | input | 1 | Serial data bit, LSB of each byte first |
| data_last | input | 1 | Marks the final data bit; starts check-bit emission |
| inv_en | input | 1 | 1: check bits inverted and residue 0xF0B8 expected; 0: plain check bits and zero residue |
| tx_bit | output | 1 | Serial check bit |
| tx_vld | output | 1 | `tx_bit` is valid (EMIT state) |
| tx_done | output | 1 | Accompanies the sixteenth check bit |
| crc_ok | output | 1 | The register holds the good-frame residue |
| crc_q | output | 16 | Parallel view of the CRC register |

## Verification
The bench checks the single-byte vector in both polarities against the literal bit strings, so a design with reversed output order or a wrong polynomial tap fails at once. It also runs multi-byte frames through a scoreboard fed by an independent MSB-first model.

Receive runs cover several faults:
- A clean frame must set `crc_ok`; a design that compared against the wrong residue keeps it low.
- A single flipped bit must clear `crc_ok`.
- An added trailing zero must clear `crc_ok` under inversion, while it passes without inversion.

A `sof` arriving together with a valid bit in mid-frame must leave the CRC of the new frame only; a design that drops the bit, or skips the preset, leaves a different value. Noise on `bit_vld` and `data_last` is driven during IDLE and EMIT; a design that did not gate these inputs by state would corrupt the register or the emitted bits. Finally, a `sof` in the middle of an emission must end `tx_vld` at once.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ABSORB = 2'd1,
        ST_EMIT   = 2'd2
    } crc_state_e;

endpackage

// File: rtl/crc16_lfsr.sv
module crc16_lfsr #(
    parameter int                 WIDTH  = 16,
    parameter logic [WIDTH-1:0]   POLY   = 16'h8408,
    parameter logic [WIDTH-1:0]   PRESET = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             preset_en,
    input  logic             absorb_en,
    input  logic             drain_en,
    input  logic             din,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] base;
    logic [WIDTH-1:0] stepped;
    logic             fb;

    // Start point of the update: fresh preset on a frame start, else the register.
    assign base = preset_en ? PRESET : q;
    // The leading bit (bit 0 in the reflected view) meets the data bit here.
    assign fb   = base[0] ^ din;

    // Each position takes its upper neighbour and, where the polynomial has a tap, the feedback.
    for (genvar i = 0; i < WIDTH - 1; i++) begin : g_tap
        assign stepped[i] = base[i+1] ^ (fb & POLY[i]);
    end
    assign stepped[WIDTH-1] = fb & POLY[WIDTH-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= PRESET;
        end else if (absorb_en) begin
            q <= stepped;
        end else if (preset_en) begin
            q <= PRESET;
        end else if (drain_en) begin
            q <= q >> 1;
        end
    end

endmodule

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
    import crc16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sof,
    input  logic       bit_vld,
    input  logic       data_last,
    output logic       preset_en,
    output logic       absorb_en,
    output logic       drain_en,
    output logic       tx_vld,
    output logic       tx_done,
    output crc_state_e state_o
);

    localparam int             CW       = $clog2(WIDTH);
    localparam logic [CW-1:0]  CNT_LAST = CW'(WIDTH - 1);

    crc_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (sof) begin
            st_d  = (bit_vld && data_last) ? ST_EMIT : ST_ABSORB;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    st_d = ST_IDLE;
                end
                ST_ABSORB: begin
                    if (bit_vld && data_last) begin
                        st_d  = ST_EMIT;
                        cnt_d = '0;
                    end
                end
                ST_EMIT: begin
                    if (cnt_q == CNT_LAST) begin
                        st_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_d = ST_IDLE;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        preset_en = sof;
        absorb_en = bit_vld && (sof || st_q == ST_ABSORB);
        drain_en  = !sof && st_q == ST_EMIT;
        tx_vld    = st_q == ST_EMIT;
        tx_done   = st_q == ST_EMIT && cnt_q == CNT_LAST;
    end

    assign state_o = st_q;

endmodule

// File: rtl/crc16_resid.sv
module crc16_resid #(
    parameter int               WIDTH   = 16,
    parameter logic [WIDTH-1:0] RESIDUE = 16'hF0B8
) (
    input  logic [WIDTH-1:0] q,
    input  logic             inv_en,
    output logic             ok
);

    // Plain check bits drive a clean frame to zero; inverted ones to a fixed pattern.
    assign ok = inv_en ? (q == RESIDUE) : (q == '0);

endmodule

// File: rtl/crc16_serial.sv
module crc16_serial
    import crc16_pkg::*;
#(
    parameter int                 WIDTH   = 16,
    parameter logic [WIDTH-1:0]   POLY    = 16'h8408,
    parameter logic [WIDTH-1:0]   PRESET  = 16'hFFFF,
    parameter logic [WIDTH-1:0]   RESIDUE = 16'hF0B8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sof,
    input  logic             bit_vld,
    input  logic             bit_in,
    input  logic             data_last,
    input  logic             inv_en,
    output logic             tx_bit,
    output logic             tx_vld,
    output logic             tx_done,
    output logic             crc_ok,
    output logic [WIDTH-1:0] crc_q
);

    logic       preset_en;
    logic       absorb_en;
    logic       drain_en;
    crc_state_e state_w;

    crc16_ctrl #(.WIDTH(WIDTH)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .sof       (sof),
        .bit_vld   (bit_vld),
        .data_last (data_last),
        .preset_en (preset_en),
        .absorb_en (absorb_en),
        .drain_en  (drain_en),
        .tx_vld    (tx_vld),
        .tx_done   (tx_done),
        .state_o   (state_w)
    );

    crc16_lfsr #(.WIDTH(WIDTH), .POLY(POLY), .PRESET(PRESET)) lfsr_i (
        .clk       (clk),
        .rst       (rst),
        .preset_en (preset_en),
        .absorb_en (absorb_en),
        .drain_en  (drain_en),
        .din       (bit_in),
        .q         (crc_q)
    );

    crc16_resid #(.WIDTH(WIDTH), .RESIDUE(RESIDUE)) resid_i (
        .q      (crc_q),
        .inv_en (inv_en),
        .ok     (crc_ok)
    );

    assign tx_bit = tx_vld & (crc_q[0] ^ inv_en);

endmodule

// File: rtl/crc16_sva.sv
module crc16_sva
    import crc16_pkg::*;
#(
    parameter int               WIDTH  = 16,
    parameter logic [WIDTH-1:0] PRESET = 16'hFFFF
) (
    input logic             clk,
    input logic             rst,
    input logic             sof,
    input logic             bit_vld,
    input logic             tx_vld,
    input logic             tx_done,
    input logic [WIDTH-1:0] crc_q,
    input crc_state_e       st
);

    localparam int RW = $clog2(WIDTH) + 1;

    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || sof || !tx_vld || tx_done) begin
            run_q <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end

    // R1
    preset_load_chk: assert property (@(posedge clk) disable iff (rst)
        (sof && !bit_vld) |=> crc_q == PRESET);

    // R4
    done_with_vld_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> tx_vld);

    // R4
    done_after_run_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> run_q == RW'(WIDTH - 1));

    // R4
    done_ends_emit_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !sof) |=> !tx_vld);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !sof) |=> $stable(crc_q));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sof && !bit_vld && !tx_vld) |=> $stable(crc_q));

    // R8
    drained_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !sof) |=> crc_q == '0);

endmodule

bind crc16_serial crc16_sva #(.WIDTH(WIDTH), .PRESET(PRESET)) sva_i (
    .clk     (clk),
    .rst     (rst),
    .sof     (sof),
    .bit_vld (bit_vld),
    .tx_vld  (tx_vld),
    .tx_done (tx_done),
    .crc_q   (crc_q),
    .st      (state_w)
);

// File: tb/crc16_serial_tb.sv
module crc16_serial_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof = 1'b0;
    logic        bit_vld = 1'b0;
    logic        bit_in = 1'b0;
    logic        data_last = 1'b0;
    logic        inv_en = 1'b1;
    logic        tx_bit, tx_vld, tx_done, crc_ok;
    logic [15:0] crc_q;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;
    bit          mon_en = 1'b1;
    logic [1:0]  expq[$];
    string       cur_req = "R4";

    always #4 clk = ~clk;

    crc16_serial dut_i (
        .clk(clk), .rst(rst), .sof(sof), .bit_vld(bit_vld), .bit_in(bit_in),
        .data_last(data_last), .inv_en(inv_en), .tx_bit(tx_bit), .tx_vld(tx_vld),
        .tx_done(tx_done), .crc_ok(crc_ok), .crc_q(crc_q)
    );

    task automatic check(input bit cond, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Scoreboard monitor: each emitted bit is popped and compared.
    always @(negedge clk) begin
        if (mon_en && tx_vld && !rst) begin
            if (expq.size() == 0) begin
                check(1'b0, cur_req, "unexpected tx bit", {30'd0, tx_bit, tx_done}, 32'd0);
            end else begin
                logic [1:0] e;
                e = expq.pop_front();
                check({tx_bit, tx_done} == e, cur_req, "tx bit/done",
                      {30'd0, tx_bit, tx_done}, {30'd0, e});
            end
        end
    end

    task automatic drive(input logic s, input logic v, input logic b, input logic l);
        @(negedge clk);
        sof = s; bit_vld = v; bit_in = b; data_last = l;
        @(posedge clk);
        #1;
    endtask

    function automatic void to_bits(input logic [7:0] bytes[$], ref logic bits[$]);
        bits.delete();
        foreach (bytes[k]) for (int i = 0; i < 8; i++) bits.push_back(bytes[k][i]);
    endfunction

    // Independent MSB-first model, polynomial 0x1021, preset 0xFFFF.
    function automatic logic [15:0] model(input logic bits[$]);
        logic [15:0] c = 16'hFFFF;
        foreach (bits[k]) begin
            logic fb;
            fb = c[15] ^ bits[k];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    function automatic logic [15:0] rev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    // Transmit a frame; noise on bit_vld/data_last during emission must be ignored.
    task automatic tx_frame(input logic [7:0] bytes[$], input logic inv,
                            input bit use_lit, input logic [15:0] lit, input string req);
        logic bits[$];
        logic [15:0] c;
        to_bits(bytes, bits);
        c = use_lit ? lit : model(bits);
        inv_en = inv;
        cur_req = req;
        for (int i = 0; i < 16; i++) begin
            logic bv;
            bv = use_lit ? c[15-i] : (c[15-i] ^ inv);
            expq.push_back({bv, (i == 15) ? 1'b1 : 1'b0});
        end
        drive(1, 0, 0, 0);
        foreach (bits[k]) drive(0, 1, bits[k], (k == bits.size() - 1) ? 1'b1 : 1'b0);
        for (int i = 0; i < 18; i++) drive(0, 1'($urandom), 1'($urandom), 1'($urandom));
        drive(0, 0, 0, 0);
        check(expq.size() == 0, req, "all check bits emitted", expq.size(), 0);
        check(tx_vld == 1'b0, "R4", "tx_vld low after emission", tx_vld, 0);
        // R8
        check(crc_q == 16'h0000, "R8", "register drained", crc_q, 0);
        expq.delete();
    endtask

    // Receive a frame with its check bits; optional fault injection.
    task automatic rx_frame(input logic [7:0] bytes[$], input logic inv, input bit flip,
                            input bit extra_zero, input logic exp_ok, input string what);
        logic bits[$];
        logic [15:0] c;
        to_bits(bytes, bits);
        c = model(bits);
        for (int i = 0; i < 16; i++) bits.push_back(c[15-i] ^ inv);
        if (flip) bits[3] = ~bits[3];
        if (extra_zero) bits.push_back(1'b0);
        inv_en = inv;
        drive(1, 0, 0, 0);
        foreach (bits[k]) drive(0, 1, bits[k], 0);
        drive(0, 0, 0, 0);
        check(crc_ok == exp_ok, "R5", what, crc_ok, exp_ok);
        if (!flip && !extra_zero)
            check(crc_q == (inv ? 16'hF0B8 : 16'h0000), "R5", {what, " residue"},
                  crc_q, inv ? 16'hF0B8 : 16'h0000);
    endtask

    initial begin
        #(8 * 150000);
        check(1'b0, "watchdog", "run timed out", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] fa[$];
        logic [7:0] fb[$];
        logic bits[$];
        logic [15:0] hold;

        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        // R1 reset state
        check(crc_q == 16'hFFFF, "R1", "reset register", crc_q, 16'hFFFF);
        check(tx_vld == 0 && tx_done == 0, "R1", "reset tx outputs", {tx_vld, tx_done}, 0);

        // R3 known vector, both polarities, against literal transmit strings
        fa = '{8'h41};
        tx_frame(fa, 1'b0, 1'b1, 16'b0101000000111010, "R3");
        tx_frame(fa, 1'b1, 1'b1, 16'b1010111111000101, "R3");

        // R4 multi-byte frames against the model
        fa = '{8'h00, 8'hFF, 8'h5A, 8'hC3};
        tx_frame(fa, 1'b1, 1'b0, 16'h0, "R4");
        fa = '{8'h12, 8'h34, 8'h56};
        tx_frame(fa, 1'b0, 1'b0, 16'h0, "R4");
        for (int t = 0; t < 4; t++) begin
            fa.delete();
            for (int i = 0; i < 2 + t; i++) fa.push_back(8'($urandom));
            tx_frame(fa, 1'(t), 1'b0, 16'h0, "R4");
        end

        // R2 register contents mid-frame, with stalls (R7) between bits
        fa = '{8'hA5, 8'h3C};
        to_bits(fa, bits);
        inv_en = 1'b1;
        drive(1, 0, 0, 0);
        check(crc_q == 16'hFFFF, "R1", "preset on sof", crc_q, 16'hFFFF);
        foreach (bits[k]) begin
            drive(0, 1, bits[k], 0);
            if (k == 5) begin
                hold = crc_q;
                drive(0, 0, ~bits[k], 1);
                // R7 stall in ABSORB
                check(crc_q == hold, "R7", "stall holds register", crc_q, hold);
            end
        end
        check(crc_q == rev16(model(bits)), "R2", "reflected register", crc_q, rev16(model(bits)));

        // R7 bits in IDLE ignored
        tx_frame(fa, 1'b0, 1'b0, 16'h0, "R7");
        for (int i = 0; i < 5; i++) drive(0, 1, 1'($urandom), 1'($urandom));
        drive(0, 0, 0, 0);
        check(crc_q == 16'h0000, "R7", "idle bits ignored", crc_q, 0);
        check(tx_vld == 1'b0, "R7", "idle data_last ignored", tx_vld, 0);

        // R6 sof coinciding with a valid bit mid-frame
        fa = '{8'h77, 8'h88};
        to_bits(fa, bits);
        drive(1, 0, 0, 0);
        for (int k = 0; k < 9; k++) drive(0, 1, bits[k], 0);
        fb = '{8'h9E, 8'h01};
        to_bits(fb, bits);
        foreach (bits[k]) drive((k == 0) ? 1'b1 : 1'b0, 1, bits[k], 0);
        drive(0, 0, 0, 0);
        check(crc_q == rev16(model(bits)), "R6", "sof with bit restarts frame",
              crc_q, rev16(model(bits)));

        // R6 sof aborts an emission
        mon_en = 1'b0;
        drive(0, 1, 1, 1);
        for (int i = 0; i < 4; i++) drive(0, 0, 0, 0);
        check(tx_vld == 1'b1, "R6", "emission running", tx_vld, 1);
        drive(1, 0, 0, 0);
        check(tx_vld == 1'b0, "R6", "sof aborts emission", tx_vld, 0);
        check(crc_q == 16'hFFFF, "R6", "abort presets", crc_q, 16'hFFFF);
        drive(0, 0, 0, 0);
        mon_en = 1'b1;

        // R5 receive side
        fa = '{8'h41};
        rx_frame(fa, 1'b0, 0, 0, 1'b1, "clean plain one byte");
        fa = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
        rx_frame(fa, 1'b1, 0, 0, 1'b1, "clean inverted");
        rx_frame(fa, 1'b0, 0, 0, 1'b1, "clean plain");
        rx_frame(fa, 1'b1, 1, 0, 1'b0, "flipped bit inverted");
        rx_frame(fa, 1'b0, 1, 0, 1'b0, "flipped bit plain");
        rx_frame(fa, 1'b1, 0, 1, 1'b0, "trailing zero inverted");
        rx_frame(fa, 1'b0, 0, 1, 1'b1, "trailing zero plain undetected");

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule